// File: doc/BRIEF.md
# SPI Host Interrupt Aggregator

This block reduces the error flags and the status flags of an SPI host controller to two interrupt lines, one for host errors and one for SPI events. Each line has an enable bit, a test bit and a sticky state bit. Software clears a state bit by pulsing the matching clear strobe. A new interrupt is considered only while its state bit is clear and its line is enabled. Each cause must also be enabled in its own per-cause enable register.

Causes are not sampled on every cycle. An evaluation pass runs in a cycle where the test register is written, or where any error-status or status input differs from its value in the previous cycle. During that pass the causes of each line are scanned in a fixed priority order, with the test bit first, and the first one present raises the line. Overflow, underflow and invalid-access errors are accepted without effect. So are the watermark and idle event enables. The bus decode and the FIFOs that produce the flags sit outside the block.

All pins are plain control and status levels. No data stream passes through the block, so it has no valid/ready handshake and applies no back-pressure.

Top module: `spi_irq_agg`

## Requirements
- R1: After reset the state bits, both interrupt lines, the line enables, the test register and the event-enable register are all 0, and the error-enable register is 5'h1F.
- R2: The error line is raised by command-busy (error-status bit 0), invalid command (bit 3) or invalid chip-select ID (bit 4). Each of these requires the error-enable bit at the same position to be set.
- R3: Overflow (error-status bit 1), underflow (bit 2) and invalid access (bit 5) never raise the error line.
- R4: The event line is raised by ready with event-enable bit 0, by TX empty with event-enable bit 1, or by RX full with event-enable bit 2.
- R5: Event-enable bits 3, 4 and 5 (RX watermark, TX watermark, idle) never raise the event line.
- R6: Writing a 1 to test bit 0 raises the error line, and writing a 1 to test bit 1 raises the event line, whatever the per-cause enables hold. The line enable and the test bit use the same positions: 0 for error, 1 for event.
- R7: A line whose enable bit is 0 is never raised. Setting the enable later does not raise the line by itself.
- R8: A state bit stays set until its clear strobe is pulsed. Clearing it while a cause is still present does not set it again until the next evaluation.
- R9: If a clear strobe and a set of the same line fall in the same cycle, the set wins. If the state bit was already set in that cycle, the set is blocked and the clear takes effect.
- R10: Each interrupt line equals its state bit ANDed with its line enable. State and lines change on the clock edge that ends the triggering cycle.
- R11: An evaluation runs only in a cycle with a test-register write or with a change on an error-status or status input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_sts_i | input | 6 | Error flags: 0 busy, 1 overflow, 2 underflow, 3 invalid command, 4 invalid chip-select ID, 5 invalid access |
| sts_ready_i | input | 1 | Controller ready for a command |
| sts_txempty_i | input | 1 | TX FIFO empty |
| sts_rxfull_i | input | 1 | RX FIFO full |
| err_en_we_i | input | 1 | Error-enable write strobe |
| err_en_wdata_i | input | 5 | Error-enable write value, bit positions as err_sts_i |
| evt_en_we_i | input | 1 | Event-enable write strobe |
| evt_en_wdata_i | input | 6 | Event-enable write value: 0 ready, 1 TX empty, 2 RX full, 3 RX watermark, 4 TX watermark, 5 idle |
| irq_en_we_i | input | 1 | Line-enable write strobe |
| irq_en_wdata_i | input | 2 | Line-enable value: 0 error, 1 event |
| irq_test_we_i | input | 1 | Test-register write strobe |
| irq_test_wdata_i | input | 2 | Test-register value: 0 error, 1 event |
| irq_clr_i | input | 2 | Write-one-to-clear strobes for the state bits |
| irq_err_o | output | 1 | Error interrupt line |
| irq_evt_o | output | 1 | Event interrupt line |
| irq_state_o | output | 2 | Interrupt state: 0 error, 1 event |

## Verification
A clear strobe and a new set condition can land on the same line in the same cycle. The bench provokes this by pulsing the clear strobe together with a test-register write. It does so once with the state bit clear, where the line must end up set, and once with it already set, where the set is blocked and the bit must end up clear. A behavioural model in the bench predicts the state and both lines on every clock. Directed checks confirm that clearing while a cause is still held does not re-raise the line until an input changes.

// File: rtl/spi_irq_pkg.sv
`timescale 1ns/1ps
package spi_irq_pkg;
  localparam int ERR_STS_W  = 6;
  localparam int ERR_EN_W   = 5;
  localparam int EVT_EN_W   = 6;
  localparam int STS_W      = 3;
  localparam int NUM_LINES  = 2;
  localparam int NUM_CAUSES = 4;

  localparam int LINE_ERR = 0;
  localparam int LINE_EVT = 1;

  localparam int ERR_BUSY   = 0;
  localparam int ERR_OVF    = 1;
  localparam int ERR_UDF    = 2;
  localparam int ERR_CMDINV = 3;
  localparam int ERR_CSID   = 4;
  localparam int ERR_ACCESS = 5;

  localparam int EVT_READY   = 0;
  localparam int EVT_TXEMPTY = 1;
  localparam int EVT_RXFULL  = 2;

  localparam logic [ERR_EN_W-1:0] ERR_EN_RESET = '1;

  typedef struct packed {
    logic rx_full;
    logic tx_empty;
    logic ready;
  } sts_t;
endpackage

// File: rtl/spi_irq_wreg.sv
`timescale 1ns/1ps
module spi_irq_wreg #(
  parameter int W = 1,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q,
  output logic [W-1:0] nxt
);
  assign nxt = we ? wdata : q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST;
    else        q <= nxt;
  end
endmodule

// File: rtl/spi_irq_chg.sv
`timescale 1ns/1ps
module spi_irq_chg #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sig,
  output logic         changed
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sig;
  end

  assign changed = |(sig ^ prev_q);
endmodule

// File: rtl/spi_irq_prio.sv
`timescale 1ns/1ps
module spi_irq_prio #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         hit
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant[i]  = req[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req[i];
  end

  assign hit = seen[N];
endmodule

// File: rtl/spi_irq_state.sv
`timescale 1ns/1ps
module spi_irq_state #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         trigger,
  input  logic [N-1:0] en_q,
  input  logic [N-1:0] en_nxt,
  input  logic [N-1:0] hit,
  input  logic [N-1:0] clr,
  output logic [N-1:0] state_q,
  output logic [N-1:0] irq_q,
  output logic [N-1:0] set
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic state_d;
    assign set[g]  = trigger & en_q[g] & ~state_q[g] & hit[g];
    assign state_d = (state_q[g] & ~clr[g]) | set[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        state_q[g] <= 1'b0;
        irq_q[g]   <= 1'b0;
      end else begin
        state_q[g] <= state_d;
        irq_q[g]   <= state_d & en_nxt[g];
      end
    end
  end
endmodule

// File: rtl/spi_irq_agg.sv
`timescale 1ns/1ps
module spi_irq_agg
  import spi_irq_pkg::*;
#(
  parameter logic [ERR_EN_W-1:0] ERR_EN_INIT = ERR_EN_RESET
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ERR_STS_W-1:0] err_sts_i,
  input  logic                 sts_ready_i,
  input  logic                 sts_txempty_i,
  input  logic                 sts_rxfull_i,
  input  logic                 err_en_we_i,
  input  logic [ERR_EN_W-1:0]  err_en_wdata_i,
  input  logic                 evt_en_we_i,
  input  logic [EVT_EN_W-1:0]  evt_en_wdata_i,
  input  logic                 irq_en_we_i,
  input  logic [NUM_LINES-1:0] irq_en_wdata_i,
  input  logic                 irq_test_we_i,
  input  logic [NUM_LINES-1:0] irq_test_wdata_i,
  input  logic [NUM_LINES-1:0] irq_clr_i,
  output logic                 irq_err_o,
  output logic                 irq_evt_o,
  output logic [NUM_LINES-1:0] irq_state_o
);
  localparam int WATCH_W = ERR_STS_W + STS_W;

  logic [ERR_EN_W-1:0]  err_en_q, err_en_nxt;
  logic [EVT_EN_W-1:0]  evt_en_q, evt_en_nxt;
  logic [NUM_LINES-1:0] line_en_q, line_en_nxt;
  logic [NUM_LINES-1:0] test_q, test_nxt;

  // Configuration registers
  spi_irq_wreg #(.W(ERR_EN_W), .RST(ERR_EN_INIT)) u_err_en (
    .clk, .rst_n, .we(err_en_we_i), .wdata(err_en_wdata_i),
    .q(err_en_q), .nxt(err_en_nxt));

  spi_irq_wreg #(.W(EVT_EN_W), .RST('0)) u_evt_en (
    .clk, .rst_n, .we(evt_en_we_i), .wdata(evt_en_wdata_i),
    .q(evt_en_q), .nxt(evt_en_nxt));

  spi_irq_wreg #(.W(NUM_LINES), .RST('0)) u_line_en (
    .clk, .rst_n, .we(irq_en_we_i), .wdata(irq_en_wdata_i),
    .q(line_en_q), .nxt(line_en_nxt));

  // Test value in force this cycle: a write is seen by its own evaluation
  spi_irq_wreg #(.W(NUM_LINES), .RST('0)) u_test (
    .clk, .rst_n, .we(irq_test_we_i), .wdata(irq_test_wdata_i),
    .q(test_q), .nxt(test_nxt));

  // Evaluation trigger: test write or any watched flag moving
  sts_t sts;
  assign sts.ready    = sts_ready_i;
  assign sts.tx_empty = sts_txempty_i;
  assign sts.rx_full  = sts_rxfull_i;

  logic [WATCH_W-1:0] watched;
  logic               watch_changed;
  logic               trigger;
  assign watched = {err_sts_i, sts};

  spi_irq_chg #(.W(WATCH_W)) u_chg (
    .clk, .rst_n, .sig(watched), .changed(watch_changed));

  assign trigger = irq_test_we_i | watch_changed;

  // Cause vectors, index 0 is highest priority
  logic [NUM_LINES-1:0][NUM_CAUSES-1:0] req;
  logic [NUM_LINES-1:0][NUM_CAUSES-1:0] grant;
  logic [NUM_LINES-1:0]                 hit;

  assign req[LINE_ERR][0] = test_nxt[LINE_ERR];
  assign req[LINE_ERR][1] = err_sts_i[ERR_BUSY]   & err_en_q[ERR_BUSY];
  assign req[LINE_ERR][2] = err_sts_i[ERR_CMDINV] & err_en_q[ERR_CMDINV];
  assign req[LINE_ERR][3] = err_sts_i[ERR_CSID]   & err_en_q[ERR_CSID];

  assign req[LINE_EVT][0] = test_nxt[LINE_EVT];
  assign req[LINE_EVT][1] = sts.ready    & evt_en_q[EVT_READY];
  assign req[LINE_EVT][2] = sts.tx_empty & evt_en_q[EVT_TXEMPTY];
  assign req[LINE_EVT][3] = sts.rx_full  & evt_en_q[EVT_RXFULL];

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_prio
    spi_irq_prio #(.N(NUM_CAUSES)) u_prio (
      .req(req[l]), .grant(grant[l]), .hit(hit[l]));
  end

  // Sticky state and registered lines
  logic [NUM_LINES-1:0] irq_q;
  logic [NUM_LINES-1:0] set_vec;

  spi_irq_state #(.N(NUM_LINES)) u_state (
    .clk, .rst_n, .trigger, .en_q(line_en_q), .en_nxt(line_en_nxt),
    .hit, .clr(irq_clr_i), .state_q(irq_state_o), .irq_q, .set(set_vec));

  assign irq_err_o = irq_q[LINE_ERR];
  assign irq_evt_o = irq_q[LINE_EVT];

  // Accepted but inert fields
  logic unused_fields;
  assign unused_fields = ^{err_en_q[ERR_UDF:ERR_OVF], evt_en_q[EVT_EN_W-1:EVT_RXFULL+1],
                           err_en_nxt, evt_en_nxt};
endmodule

// File: rtl/spi_irq_agg_chk.sv
`timescale 1ns/1ps
module spi_irq_agg_chk
  import spi_irq_pkg::*;
(
  input logic                                 clk,
  input logic                                 rst_n,
  input logic [ERR_STS_W-1:0]                 err_sts_i,
  input logic                                 sts_ready_i,
  input logic                                 sts_txempty_i,
  input logic                                 sts_rxfull_i,
  input logic                                 irq_test_we_i,
  input logic [NUM_LINES-1:0]                 irq_test_wdata_i,
  input logic [NUM_LINES-1:0]                 irq_clr_i,
  input logic                                 irq_err_o,
  input logic                                 irq_evt_o,
  input logic [NUM_LINES-1:0]                 irq_state_o,
  input logic [ERR_EN_W-1:0]                  err_en_q,
  input logic [2:0]                           evt_en_q,
  input logic [NUM_LINES-1:0]                 line_en_q,
  input logic [NUM_LINES-1:0]                 test_q,
  input logic                                 trigger,
  input logic [NUM_LINES-1:0]                 set_vec,
  input logic [NUM_LINES-1:0][NUM_CAUSES-1:0] grant
);
  logic [NUM_LINES-1:0] test_now;
  logic err_cause, evt_cause;
  assign test_now  = irq_test_we_i ? irq_test_wdata_i : test_q;
  assign err_cause = test_now[0] | (err_sts_i[0] & err_en_q[0]) |
                     (err_sts_i[3] & err_en_q[3]) | (err_sts_i[4] & err_en_q[4]);
  assign evt_cause = test_now[1] | (sts_ready_i & evt_en_q[0]) |
                     (sts_txempty_i & evt_en_q[1]) | (sts_rxfull_i & evt_en_q[2]);

  logic unused_chk;
  assign unused_chk = ^{err_en_q[2:1], err_sts_i[2:1], err_sts_i[5]};

  assert_line_err_tracks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err_o == (irq_state_o[0] && line_en_q[0]));
  assert_line_evt_tracks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_evt_o == (irq_state_o[1] && line_en_q[1]));
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_state_o[0] && !irq_clr_i[0] |=> irq_state_o[0]);
  assert_evt_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_state_o[1] && !irq_clr_i[1] |=> irq_state_o[1]);
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    set_vec[0] |=> irq_state_o[0]);
  assert_set_wins_evt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    set_vec[1] |=> irq_state_o[1]);
  assert_no_eval_no_raise_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !trigger && irq_state_o == 2'b00 |=> irq_state_o == 2'b00);
  assert_quiet_errors_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !err_cause && !irq_state_o[0] |=> !irq_state_o[0]);
  assert_quiet_events_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_cause && !irq_state_o[1] |=> !irq_state_o[1]);
  assert_line_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    line_en_q == 2'b00 && irq_state_o == 2'b00 |=> irq_state_o == 2'b00);
  assert_single_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant[0]) && $onehot0(grant[1]));
endmodule

bind spi_irq_agg spi_irq_agg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .err_sts_i(err_sts_i),
  .sts_ready_i(sts_ready_i), .sts_txempty_i(sts_txempty_i), .sts_rxfull_i(sts_rxfull_i),
  .irq_test_we_i(irq_test_we_i), .irq_test_wdata_i(irq_test_wdata_i),
  .irq_clr_i(irq_clr_i), .irq_err_o(irq_err_o), .irq_evt_o(irq_evt_o),
  .irq_state_o(irq_state_o), .err_en_q(err_en_q), .evt_en_q(evt_en_q[2:0]),
  .line_en_q(line_en_q), .test_q(test_q), .trigger(trigger),
  .set_vec(set_vec), .grant(grant));

// File: tb/spi_irq_agg_test.sv
`timescale 1ns/1ps
module spi_irq_agg_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [5:0] err_sts = '0;
  logic rdy = 0, txe = 0, rxf = 0;
  logic eew = 0, vew = 0, iew = 0, tw = 0;
  logic [4:0] eed = '0;
  logic [5:0] ved = '0;
  logic [1:0] ied = '0, td = '0, clr = '0;
  logic irq_err, irq_evt;
  logic [1:0] state;

  spi_irq_agg uut (
    .clk(clk), .rst_n(rst_n), .err_sts_i(err_sts),
    .sts_ready_i(rdy), .sts_txempty_i(txe), .sts_rxfull_i(rxf),
    .err_en_we_i(eew), .err_en_wdata_i(eed),
    .evt_en_we_i(vew), .evt_en_wdata_i(ved),
    .irq_en_we_i(iew), .irq_en_wdata_i(ied),
    .irq_test_we_i(tw), .irq_test_wdata_i(td),
    .irq_clr_i(clr), .irq_err_o(irq_err), .irq_evt_o(irq_evt),
    .irq_state_o(state));

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // Behavioural reference, updated on every rising edge
  logic [4:0] m_err_en = 5'h1F;
  logic [5:0] m_evt_en = '0;
  logic [1:0] m_en = '0, m_test = '0, m_state = '0, m_irq = '0;
  logic [5:0] p_err = '0;
  logic [2:0] p_sts = '0;
  bit m_live = 0;

  always @(posedge clk) begin
    logic [1:0] t_eff, causes, sets;
    bit trig;
    if (!rst_n) begin
      m_err_en = 5'h1F; m_evt_en = '0; m_en = '0; m_test = '0;
      m_state = '0; m_irq = '0; p_err = '0; p_sts = '0; m_live = 0;
    end else begin
      t_eff = tw ? td : m_test;
      trig = tw || (err_sts != p_err) || ({rxf, txe, rdy} != p_sts);
      causes[0] = t_eff[0] || (err_sts[0] && m_err_en[0]) ||
                  (err_sts[3] && m_err_en[3]) || (err_sts[4] && m_err_en[4]);
      causes[1] = t_eff[1] || (rdy && m_evt_en[0]) ||
                  (txe && m_evt_en[1]) || (rxf && m_evt_en[2]);
      sets = trig ? (causes & m_en & ~m_state) : 2'b00;
      m_state = (m_state & ~clr) | sets;
      if (eew) m_err_en = eed;
      if (vew) m_evt_en = ved;
      if (iew) m_en = ied;
      if (tw)  m_test = td;
      p_err = err_sts;
      p_sts = {rxf, txe, rdy};
      m_irq = m_state & m_en;
      m_live = 1;
    end
  end

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] obs();
    return {irq_evt, irq_err, state};
  endfunction

  always @(negedge clk) begin
    if (rst_n && m_live && !done)
      chk("R10 per-cycle model compare", obs(), {m_irq[1], m_irq[0], m_state});
  end

  task automatic cyc(); @(negedge clk); endtask
  task automatic wr_line_en(logic [1:0] v); ied = v; iew = 1; cyc(); iew = 0; endtask
  task automatic wr_err_en(logic [4:0] v);  eed = v; eew = 1; cyc(); eew = 0; endtask
  task automatic wr_evt_en(logic [5:0] v);  ved = v; vew = 1; cyc(); vew = 0; endtask
  task automatic wr_test(logic [1:0] v);    td = v;  tw = 1;  cyc(); tw = 0;  endtask
  task automatic pulse_clr(logic [1:0] v);  clr = v; cyc(); clr = 2'b00; endtask

  initial begin
    repeat (3) cyc();
    chk("R1 reset state and lines", obs(), 4'b0000);
    rst_n = 1;
    cyc();
    wr_line_en(2'b11);
    chk("R7 enable write alone does not raise", obs(), 4'b0000);

    err_sts = 6'b000001; cyc();
    chk("R1 R2 busy with reset error-enable", obs(), 4'b0101);
    repeat (3) cyc();
    chk("R8 state sticky", obs(), 4'b0101);
    pulse_clr(2'b01);
    chk("R8 clear with cause held", obs(), 4'b0000);
    cyc();
    chk("R11 no re-raise without change", obs(), 4'b0000);
    err_sts = 6'b000000; cyc();
    chk("R11 change with no cause", obs(), 4'b0000);
    err_sts = 6'b000001; cyc();
    chk("R11 change re-raises", obs(), 4'b0101);
    pulse_clr(2'b01); err_sts = '0; cyc();

    err_sts = 6'b100110; repeat (2) cyc();
    chk("R3 overflow underflow access quiet", obs(), 4'b0000);
    err_sts = '0; cyc();

    err_sts = 6'b001000; cyc();
    chk("R2 invalid command", obs(), 4'b0101);
    pulse_clr(2'b01); err_sts = '0; cyc();
    err_sts = 6'b010000; cyc();
    chk("R2 invalid chip-select", obs(), 4'b0101);
    pulse_clr(2'b01); err_sts = '0; cyc();
    chk("R2 cleared", obs(), 4'b0000);
    wr_err_en(5'h00);
    err_sts = 6'b011001; cyc();
    chk("R2 masked by error-enable", obs(), 4'b0000);
    err_sts = '0; cyc();
    wr_err_en(5'h1F);

    wr_evt_en(6'b111000);
    rdy = 1; txe = 1; rxf = 1; cyc();
    chk("R5 watermark idle enables quiet", obs(), 4'b0000);
    rdy = 0; txe = 0; rxf = 0; cyc();
    wr_evt_en(6'b000001);
    rdy = 1; cyc();
    chk("R4 ready event", obs(), 4'b1010);
    pulse_clr(2'b10); rdy = 0;
    wr_evt_en(6'b000010);
    txe = 1; cyc();
    chk("R4 tx empty event", obs(), 4'b1010);
    pulse_clr(2'b10); txe = 0;
    wr_evt_en(6'b000100);
    rxf = 1; cyc();
    chk("R4 rx full event", obs(), 4'b1010);
    pulse_clr(2'b10); rxf = 0; cyc();
    chk("R4 cleared", obs(), 4'b0000);

    wr_err_en(5'h00); wr_evt_en(6'h00);
    wr_test(2'b11);
    chk("R6 test bits raise both lines", obs(), 4'b1111);
    pulse_clr(2'b11);
    chk("R6 cleared with test held", obs(), 4'b0000);
    wr_test(2'b00);
    wr_err_en(5'h1F);

    wr_line_en(2'b00);
    wr_test(2'b01);
    chk("R7 disabled line not raised", obs(), 4'b0000);
    wr_line_en(2'b01);
    chk("R7 enabling later does not raise", obs(), 4'b0000);
    wr_test(2'b01);
    chk("R7 raised after enable and trigger", obs(), 4'b0101);
    wr_line_en(2'b00);
    chk("R10 line low with state kept", obs(), 4'b0001);
    wr_line_en(2'b01);
    chk("R10 line back with enable", obs(), 4'b0101);

    clr = 2'b01; td = 2'b01; tw = 1; cyc(); clr = 2'b00; tw = 0;
    chk("R9 set blocked while state set, clear wins", obs(), 4'b0000);
    clr = 2'b01; td = 2'b01; tw = 1; cyc(); clr = 2'b00; tw = 0;
    chk("R9 set beats clear", obs(), 4'b0101);
    pulse_clr(2'b01); wr_test(2'b00); cyc();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog R11 actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule